// File: doc/BRIEF.md
# Configurable Pad Input/Output Cell

This block is the programmable cell between one package pad and the internal logic of a reconfigurable array. A static nine-bit configuration word sets its behaviour. On the receive side, the raw pad level goes straight to the core. The same level also feeds a storage element, and the stored value is a second, separate output. That storage element is either an edge-triggered flip-flop or a level-sensitive latch.

On the transmit side, the value sent to the pad comes either from an output flip-flop or directly from the core signal. The data and the drive-disable control can each be inverted. A passive pull-up request is brought out as its own signal. The pad is modelled as four separate signals: data in, data out, output enable and pull-up enable.

Each storage element takes its clock from one of two clock lines, `clkA` or `clkB`. A single clock-sense bit flips the active edge, or the transparent level, of both elements together, because that sense belongs to the clock net and not to the cell. Both storage elements clear to 0 whenever the active-low reset is low or configuration loading is in progress.

Top module: `pad_io_cell`

## Requirements
- R1: `directIn` equals `padIn` at all times, whatever the configuration.
- R2: With `cfgWord[0]`=0 (flip-flop) and `cfgWord[7]`=0, `regIn` takes the value of `padIn` on each rising edge of the selected input clock and holds it between edges.
- R3: With `cfgWord[0]`=1 (latch) and `cfgWord[7]`=0, `regIn` follows `padIn` while the selected input clock is low. It holds the last value while that clock is high.
- R4: With `cfgWord[7]`=1, the flip-flop captures on the falling edge and the latch is transparent while the clock is high. The same sense applies to the output flip-flop.
- R5: `cfgWord[1]` selects the input storage clock: 0 for `clkA`, 1 for `clkB`.
- R6: While `rstN` is 0 or `cfgBusy` is 1, both storage elements read 0.
- R7: With `cfgWord[3]`=1, the pad data comes from an output flip-flop. That flip-flop captures `outData` on the active edge of the clock chosen by `cfgWord[2]` (0 for `clkA`, 1 for `clkB`).
- R8: With `cfgWord[3]`=0, `outData` drives the pad directly. In both data paths, `cfgWord[4]`=1 inverts `padOut`.
- R9: `padOe` is the inverse of `tsCtl` when `cfgWord[5]`=0, so a high `tsCtl` floats the pad. When `cfgWord[5]`=1, `padOe` equals `tsCtl`.
- R10: `padPull` equals `cfgWord[6]`.
- R11: `cfgWord[8]` is reserved and has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkA | input | 1 | First edge clock line |
| clkB | input | 1 | Second edge clock line |
| rstN | input | 1 | Global reset, active low |
| cfgBusy | input | 1 | High while configuration is loading; holds storage cleared |
| cfgWord | input | 9 | Static configuration word |
| padIn | input | 1 | Level received from the pad |
| directIn | output | 1 | Unregistered pad level to the core |
| regIn | output | 1 | Stored pad level to the core |
| outData | input | 1 | Data from the core toward the pad |
| tsCtl | input | 1 | Drive-disable control from the core, before inversion |
| padOut | output | 1 | Data driven to the pad |
| padOe | output | 1 | Pad driver enable |
| padPull | output | 1 | Passive pull-up request |

## Verification
The hardest behaviour to reach from the ports is the latch closing and holding while the pad keeps toggling, especially under inverted clock sense on the slower second clock line. To exercise it, the stimulus moves `padIn` on a grid offset from both clock lines. The two clocks run at unrelated periods, so over a run the data lands in every phase of each clock. The bench steps through all 512 configuration words, and inserts mid-run reset pulses in some of them. A behavioural reference tracks clock levels and edges, and it is compared with the outputs every cycle.

// File: rtl/pad_io_pkg.sv
package pad_io_pkg;
  localparam int CFG_W     = 9;
  localparam int B_LATCH   = 0;
  localparam int B_INSEL   = 1;
  localparam int B_OUTSEL  = 2;
  localparam int B_OUTREG  = 3;
  localparam int B_OUTINV  = 4;
  localparam int B_TSINV   = 5;
  localparam int B_PULL    = 6;
  localparam int B_CKINV   = 7;
  localparam int USED_W    = B_CKINV + 1;

  typedef struct packed {
    logic inClk;
    logic outClk;
    logic rst;
    logic useLatch;
    logic useOutReg;
    logic invOut;
    logic invTs;
    logic pullOn;
  } strobe_t;
endpackage

// File: rtl/pad_io_ctrl.sv
module pad_io_ctrl
  import pad_io_pkg::*;
(
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  logic              cfgBusy,
  input  logic [USED_W-1:0] cfg,
  output strobe_t           st
);
  logic ckInv;
  assign ckInv = cfg[B_CKINV];

  always_comb begin
    st.inClk     = (cfg[B_INSEL]  ? clkB : clkA) ^ ckInv;
    st.outClk    = (cfg[B_OUTSEL] ? clkB : clkA) ^ ckInv;
    st.rst       = ~rstN | cfgBusy;
    st.useLatch  = cfg[B_LATCH];
    st.useOutReg = cfg[B_OUTREG];
    st.invOut    = cfg[B_OUTINV];
    st.invTs     = cfg[B_TSINV];
    st.pullOn    = cfg[B_PULL];
  end
endmodule

// File: rtl/pad_io_dp.sv
module pad_io_dp
  import pad_io_pkg::*;
(
  input  strobe_t st,
  input  logic    padIn,
  input  logic    outData,
  input  logic    tsCtl,
  output logic    directIn,
  output logic    regIn,
  output logic    padOut,
  output logic    padOe,
  output logic    padPull
);
  logic inClk, outClk, rst;
  logic inFfQ, inLatQ, outFfQ;

  assign inClk  = st.inClk;
  assign outClk = st.outClk;
  assign rst    = st.rst;

  always_ff @(posedge inClk or posedge rst) begin
    if (rst) inFfQ <= 1'b0;
    else     inFfQ <= padIn;
  end

  always_latch begin
    if (rst)         inLatQ = 1'b0;
    else if (!inClk) inLatQ = padIn;
  end

  always_ff @(posedge outClk or posedge rst) begin
    if (rst) outFfQ <= 1'b0;
    else     outFfQ <= outData;
  end

  assign directIn = padIn;
  assign regIn    = st.useLatch ? inLatQ : inFfQ;
  assign padOut   = (st.useOutReg ? outFfQ : outData) ^ st.invOut;
  assign padOe    = ~(tsCtl ^ st.invTs);
  assign padPull  = st.pullOn;
endmodule

// File: rtl/pad_io_cell.sv
module pad_io_cell
  import pad_io_pkg::*;
(
  input  logic             clkA,
  input  logic             clkB,
  input  logic             rstN,
  input  logic             cfgBusy,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             padIn,
  output logic             directIn,
  output logic             regIn,
  input  logic             outData,
  input  logic             tsCtl,
  output logic             padOut,
  output logic             padOe,
  output logic             padPull
);
  strobe_t st;
  logic unusedRsv;
  assign unusedRsv = cfgWord[CFG_W-1];

  pad_io_ctrl u_ctrl (
    .clkA(clkA), .clkB(clkB), .rstN(rstN), .cfgBusy(cfgBusy),
    .cfg(cfgWord[USED_W-1:0]), .st(st)
  );

  pad_io_dp u_dp (
    .st(st), .padIn(padIn), .outData(outData), .tsCtl(tsCtl),
    .directIn(directIn), .regIn(regIn), .padOut(padOut),
    .padOe(padOe), .padPull(padPull)
  );
endmodule

// File: rtl/pad_io_cell_chk.sv
module pad_io_cell_chk
  import pad_io_pkg::*;
(
  input logic             clkA,
  input logic             rstN,
  input logic             cfgBusy,
  input logic [CFG_W-1:0] cfgWord,
  input logic             padIn,
  input logic             directIn,
  input logic             regIn,
  input logic             outData,
  input logic             tsCtl,
  input logic             padOut,
  input logic             padOe,
  input logic             padPull
);
  logic rstAny;
  assign rstAny = !rstN || cfgBusy;

  // R1
  direct_follow_chk: assert property (@(posedge clkA) disable iff (rstAny)
    directIn == padIn);

  // R6
  reset_clear_chk: assert property (@(posedge clkA)
    cfgBusy |-> (regIn == 1'b0));

  // R2
  ff_capture_chk: assert property (@(posedge clkA) disable iff (rstAny)
    (!cfgWord[B_LATCH] && !cfgWord[B_INSEL] && !cfgWord[B_CKINV])
      |=> (regIn == $past(padIn)));

  // R3
  latch_pass_chk: assert property (@(posedge clkA) disable iff (rstAny)
    (cfgWord[B_LATCH] && !cfgWord[B_INSEL] && !cfgWord[B_CKINV])
      |-> (regIn == padIn));

  // R8
  direct_out_chk: assert property (@(posedge clkA) disable iff (rstAny)
    !cfgWord[B_OUTREG] |-> (padOut == (outData ^ cfgWord[B_OUTINV])));

  // R9
  oe_float_chk: assert property (@(posedge clkA) disable iff (rstAny)
    (tsCtl && !cfgWord[B_TSINV]) |-> !padOe);

  // R10
  pull_req_chk: assert property (@(posedge clkA) disable iff (rstAny)
    padPull == cfgWord[B_PULL]);
endmodule

bind pad_io_cell pad_io_cell_chk u_chk (
  .clkA(clkA), .rstN(rstN), .cfgBusy(cfgBusy), .cfgWord(cfgWord),
  .padIn(padIn), .directIn(directIn), .regIn(regIn), .outData(outData),
  .tsCtl(tsCtl), .padOut(padOut), .padOe(padOe), .padPull(padPull)
);

// File: tb/pad_io_cell_bench.sv
`timescale 1ns/10ps
module pad_io_cell_bench;
  logic clkA = 1'b0, clkB = 1'b0;
  logic rstN = 1'b0, cfgBusy = 1'b1;
  logic [8:0] cfgWord = '0;
  logic padIn = 1'b0, outData = 1'b0, tsCtl = 1'b0;
  logic directIn, regIn, padOut, padOe, padPull;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clkA = ~clkA;
  always #3.5 clkB = ~clkB;

  pad_io_cell u_pad_io_cell (
    .clkA(clkA), .clkB(clkB), .rstN(rstN), .cfgBusy(cfgBusy),
    .cfgWord(cfgWord), .padIn(padIn), .directIn(directIn), .regIn(regIn),
    .outData(outData), .tsCtl(tsCtl), .padOut(padOut), .padOe(padOe),
    .padPull(padPull)
  );

  // behavioural reference: tracks clock levels, detects edges and windows
  logic refIn = 1'b0, refOut = 1'b0;
  logic prevInLvl = 1'b0, prevOutLvl = 1'b0;
  always @(clkA or clkB or padIn or outData or rstN or cfgBusy or cfgWord) begin
    logic inLvl, outLvl;
    inLvl  = (cfgWord[1] ? clkB : clkA) ^ cfgWord[7];
    outLvl = (cfgWord[2] ? clkB : clkA) ^ cfgWord[7];
    if (!rstN || cfgBusy) begin
      refIn = 1'b0;
      refOut = 1'b0;
    end else begin
      if (cfgWord[0]) begin
        if (inLvl == 1'b0) refIn = padIn;
      end else if (inLvl && !prevInLvl) begin
        refIn = padIn;
      end
      if (outLvl && !prevOutLvl) refOut = outData;
    end
    prevInLvl  = inLvl;
    prevOutLvl = outLvl;
  end

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s cfg=%03h t=%0t actual=%b expected=%b",
               tag, cfgWord, $time, act, exp);
    end
  endtask

  task automatic compareAll();
    string inTag, outTag, pullTag;
    logic expOut, expOe;
    if (!rstN || cfgBusy)   inTag = "R6";
    else if (cfgWord[1])    inTag = "R5";
    else if (cfgWord[7])    inTag = "R4";
    else if (cfgWord[0])    inTag = "R3";
    else                    inTag = "R2";
    outTag  = cfgWord[3] ? "R7" : "R8";
    pullTag = cfgWord[8] ? "R11" : "R10";
    expOut = cfgWord[3] ? refOut : outData;
    if (cfgWord[4]) expOut = ~expOut;
    expOe = cfgWord[5] ? tsCtl : ~tsCtl;
    check("R1", directIn, padIn);
    check(inTag, regIn, refIn);
    check(outTag, padOut, expOut);
    check("R9", padOe, expOe);
    check(pullTag, padPull, cfgWord[6]);
  endtask

  initial begin
    #1.25;
    // R6: reset state before any configuration
    #2.5; compareAll(); #2.5;
    rstN = 1'b1;
    // R11: loop covers words with the reserved bit set and clear
    for (int c = 0; c < 512; c++) begin
      cfgBusy = 1'b1;
      cfgWord = c[8:0];
      padIn = $urandom_range(1); outData = $urandom_range(1);
      #2.5; compareAll(); #2.5;
      cfgBusy = 1'b0;
      for (int k = 0; k < 14; k++) begin
        padIn   = $urandom_range(1);
        outData = $urandom_range(1);
        tsCtl   = $urandom_range(1);
        if (c % 37 == 5 && (k == 6 || k == 7)) rstN = 1'b0; // R6 mid-run
        else rstN = 1'b1;
        #2.5; compareAll(); #2.5;
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired t=%0t actual=running expected=done", $time);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule